// File: doc/BRIEF.md
# Iterative Shift and Rotate Unit with Condition Flags

This block carries out the shift and rotate group of a CISC execution core. It handles eight operations: arithmetic shift, logical shift, plain rotate and rotate through the extend flag, each to the left or to the right. Operands may be byte, word or long. The count comes either from a 3-bit immediate field or from a register value. The unit returns the shifted operand together with five condition flags: extend (X), negative (N), zero (Z), overflow (V) and carry (C).

The datapath moves one bit per clock. A `start` pulse seen while the unit is idle latches the operand and the controls in a setup cycle. Each later clock moves the operand by one bit until the count is used up. Then `done` pulses for one cycle, and the result and flags appear on registered outputs that hold until the next completion. A memory form works on the low word only, by exactly one bit, and ignores the size and count inputs. Operand fetch and writeback belong to the surrounding core.

Top module: `shrot_unit`

## Requirements
- R1: `kind_sel` encodes the operation type: 00 arithmetic, 01 logical, 11 rotate, 10 rotate through X. `go_left` is 1 for left and 0 for right. `size_sel` 00/01/10 selects byte/word/long, with a most significant bit at 7/15/31. Left shifts fill with zero, logical right fills with zero, arithmetic right replicates the sign bit, and rotates feed the bit that leaves into the vacated end.
- R2: With `cnt_from_reg`=0, `cnt_imm` values 1..7 give that count and 0 gives 8. With `cnt_from_reg`=1, the count is `cnt_reg` modulo 64. Counts at or beyond the operand width leave all fill bits.
- R3: For the arithmetic type, `v_out` is 1 when the most significant bit (at the selected size) changed at any step of the shift. For the other three types it is 0.
- R4: `x_out` takes the last bit moved out. It keeps `x_in` when the count is zero. For plain rotates it always equals `x_in`.
- R5: `c_out` takes the last bit moved out. It is 0 when the count is zero, except for rotate through X, where it equals `x_in`.
- R6: `n_out` is the result's most significant bit at the selected size. `z_out` is 1 when the result is zero within that size. Result bits above the size keep the operand's value.
- R7: With `mem_form`=1 the operation acts on the low word and moves it by exactly one bit, whatever the values of `size_sel`, `cnt_imm`, `cnt_from_reg` and `cnt_reg`.
- R8: For an effective count N, `done` rises at the Nth clock edge after the edge that accepts `start`, or at that same edge when N is 0. `busy` is high in between. `result` and the flags change only at an edge that raises `done`.
- R9: A `start` that arrives while `busy` is high is ignored. The operation in flight completes with its own result and flags.
- R10: After synchronous reset `busy`, `done`, `result` and all five flags are 0.
- R11: Rotate through X treats X and the operand as one ring of width+1 bits. X is refreshed at every step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| opnd | input | DW | Operand |
| size_sel | input | 2 | Operand size code |
| kind_sel | input | 2 | Operation type code |
| go_left | input | 1 | Direction: 1 left, 0 right |
| cnt_from_reg | input | 1 | Count source: 1 register value, 0 immediate |
| cnt_imm | input | 3 | Immediate count field |
| cnt_reg | input | RW | Register count value |
| mem_form | input | 1 | Word, single-bit memory form |
| x_in | input | 1 | Incoming extend flag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | DW | Shifted or rotated operand |
| x_out | output | 1 | Extend flag |
| n_out | output | 1 | Negative flag |
| z_out | output | 1 | Zero flag |
| v_out | output | 1 | Overflow flag |
| c_out | output | 1 | Carry flag |

## Verification
Operand patterns are chosen so that each type and direction leaves a different trace. A lone high bit at the sign position tells a rotate from a shift. An 0x81 byte under an arithmetic right shift shows sign replication, which a logical shift would not give. A pattern that crosses the sign position once and another that never reaches it separate the accumulated overflow rule from a check of the final sign alone. Zero counts given as register values of 64 cover the X-hold and the carry-clear or carry-from-X cases, and show that the modulo is applied. A 33-bit logical shift of a long operand covers counts beyond the width. Operands with non-zero upper bytes check the pass-through above the size. The latency of every operation is measured against its effective count.

// File: rtl/shrot_pkg.sv
package shrot_pkg;
  typedef enum logic [1:0] {
    K_ARITH = 2'b00,
    K_LOGIC = 2'b01,
    K_XROT  = 2'b10,
    K_ROT   = 2'b11
  } kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_LONG = 2'b10;
endpackage

// File: rtl/shrot_count.sv
// Count decode: immediate 0 means 8, register counts taken modulo 2**CW,
// memory form always one step.
module shrot_count #(
  parameter int CW = 6,
  parameter int RW = 32
) (
  input  logic          from_reg,
  input  logic [2:0]    imm,
  input  logic [RW-1:0] regv,
  input  logic          mem,
  output logic [CW-1:0] cnt
);
  localparam logic [RW-1:0] MODV = RW'(1 << CW);

  always_comb begin
    if (mem)
      cnt = CW'(1);
    else if (from_reg)
      cnt = CW'(regv % MODV);
    else if (imm == 3'd0)
      cnt = CW'(8);
    else
      cnt = CW'(imm);
  end
endmodule

// File: rtl/shrot_step.sv
// One single-bit move of the working operand at the selected size.
module shrot_step import shrot_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] w,
  input  logic [1:0]    size,
  input  kind_e         kind,
  input  logic          left,
  input  logic          x,
  output logic [DW-1:0] w_nxt,
  output logic          out_bit,
  output logic          msb_flip
);
  localparam int IW = $clog2(DW);

  logic [DW-1:0] mask, raw;
  logic [IW-1:0] m;
  logic          msb_old, fill_lo, fill_hi;

  always_comb begin
    case (size)
      SZ_BYTE: begin mask = DW'(8'hFF);    m = IW'(7);  end
      SZ_WORD: begin mask = DW'(16'hFFFF); m = IW'(15); end
      default: begin mask = '1;            m = IW'(DW-1); end
    endcase
    msb_old = w[m];
    case (kind)
      K_ROT:   begin fill_lo = msb_old; fill_hi = w[0];   end
      K_XROT:  begin fill_lo = x;       fill_hi = x;      end
      K_ARITH: begin fill_lo = 1'b0;    fill_hi = msb_old; end
      default: begin fill_lo = 1'b0;    fill_hi = 1'b0;   end
    endcase
    if (left) begin
      raw     = (w << 1) | DW'(fill_lo);
      out_bit = msb_old;
    end else begin
      raw     = ((w & mask) >> 1) | (DW'(fill_hi) << m);
      out_bit = w[0];
    end
    w_nxt    = (w & ~mask) | (raw & mask);
    msb_flip = w_nxt[m] ^ msb_old;
  end
endmodule

// File: rtl/shrot_flags.sv
// Result flag derivation at the selected size.
module shrot_flags import shrot_pkg::*; #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] w,
  input  logic [1:0]    size,
  input  kind_e         kind,
  input  logic          x_acc,
  input  logic          c_acc,
  input  logic          v_acc,
  output logic [4:0]    xnzvc
);
  logic [DW-1:0] mask;
  logic          n, z;

  always_comb begin
    case (size)
      SZ_BYTE: begin mask = DW'(8'hFF);    n = w[7];    end
      SZ_WORD: begin mask = DW'(16'hFFFF); n = w[15];   end
      default: begin mask = '1;            n = w[DW-1]; end
    endcase
    z     = ((w & mask) == '0);
    xnzvc = {x_acc, n, z, v_acc & (kind == K_ARITH), c_acc};
  end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit import shrot_pkg::*; #(
  parameter int DW = 32,
  parameter int CW = 6,
  parameter int RW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] opnd,
  input  logic [1:0]    size_sel,
  input  logic [1:0]    kind_sel,
  input  logic          go_left,
  input  logic          cnt_from_reg,
  input  logic [2:0]    cnt_imm,
  input  logic [RW-1:0] cnt_reg,
  input  logic          mem_form,
  input  logic          x_in,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] result,
  output logic          x_out,
  output logic          n_out,
  output logic          z_out,
  output logic          v_out,
  output logic          c_out
);
  logic [DW-1:0] w_q, nxt_w, st_w;
  logic          x_q, c_q, v_q, nxt_x, nxt_c, nxt_v;
  logic [CW-1:0] rem_q, cnt_eff;
  logic [1:0]    size_q, eff_size, fl_size;
  kind_e         kind_q, kind_in, fl_kind;
  logic          left_q, st_out, st_flip, accept, finish;
  logic [4:0]    fl;

  assign kind_in  = kind_e'(kind_sel);
  assign eff_size = mem_form ? SZ_WORD : size_sel;
  assign accept   = start & ~busy;

  shrot_count #(.CW(CW), .RW(RW)) u_cnt (
    .from_reg(cnt_from_reg), .imm(cnt_imm), .regv(cnt_reg),
    .mem(mem_form), .cnt(cnt_eff)
  );

  shrot_step #(.DW(DW)) u_step (
    .w(w_q), .size(size_q), .kind(kind_q), .left(left_q), .x(x_q),
    .w_nxt(st_w), .out_bit(st_out), .msb_flip(st_flip)
  );

  always_comb begin
    nxt_w   = w_q;
    nxt_x   = x_q;
    nxt_c   = c_q;
    nxt_v   = v_q;
    fl_size = size_q;
    fl_kind = kind_q;
    finish  = 1'b0;
    if (accept) begin
      nxt_w   = opnd;
      nxt_x   = x_in;
      nxt_c   = (kind_in == K_XROT) ? x_in : 1'b0;
      nxt_v   = 1'b0;
      fl_size = eff_size;
      fl_kind = kind_in;
      finish  = (cnt_eff == '0);
    end else if (busy) begin
      nxt_w  = st_w;
      nxt_x  = (kind_q == K_ROT) ? x_q : st_out;
      nxt_c  = st_out;
      nxt_v  = v_q | (st_flip & (kind_q == K_ARITH));
      finish = (rem_q == CW'(1));
    end
  end

  shrot_flags #(.DW(DW)) u_flags (
    .w(nxt_w), .size(fl_size), .kind(fl_kind),
    .x_acc(nxt_x), .c_acc(nxt_c), .v_acc(nxt_v), .xnzvc(fl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q    <= '0;
      x_q    <= 1'b0;
      c_q    <= 1'b0;
      v_q    <= 1'b0;
      rem_q  <= '0;
      size_q <= SZ_BYTE;
      kind_q <= K_ARITH;
      left_q <= 1'b0;
      busy   <= 1'b0;
      done   <= 1'b0;
      result <= '0;
      {x_out, n_out, z_out, v_out, c_out} <= '0;
    end else begin
      w_q  <= nxt_w;
      x_q  <= nxt_x;
      c_q  <= nxt_c;
      v_q  <= nxt_v;
      done <= finish;
      if (accept) begin
        size_q <= eff_size;
        kind_q <= kind_in;
        left_q <= go_left;
        rem_q  <= cnt_eff;
        busy   <= (cnt_eff != '0);
      end else if (busy) begin
        rem_q <= rem_q - CW'(1);
        if (rem_q == CW'(1)) busy <= 1'b0;
      end
      if (finish) begin
        result <= nxt_w;
        {x_out, n_out, z_out, v_out, c_out} <= fl;
      end
    end
  end
endmodule

// File: rtl/shrot_chk.sv
module shrot_chk import shrot_pkg::*; #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          x_in,
  input logic          busy,
  input logic          done,
  input logic [DW-1:0] result,
  input logic          x_out,
  input logic          n_out,
  input logic          v_out,
  input kind_e         kind_q,
  input logic [1:0]    size_q
);
  logic x_cap;
  logic msb_at_size;

  always_ff @(posedge clk) begin
    if (rst) x_cap <= 1'b0;
    else if (start && !busy) x_cap <= x_in;
  end

  always_comb begin
    case (size_q)
      SZ_BYTE: msb_at_size = result[7];
      SZ_WORD: msb_at_size = result[15];
      default: msb_at_size = result[DW-1];
    endcase
  end

  // R8: completion never overlaps an operation in flight
  a_r8_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: an accepted start either completes at once or raises busy
  a_r8_start_response: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (busy || done));

  // R8: the result moves only together with done
  a_r8_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(result));

  // R3: overflow only for the arithmetic type
  a_r3_v_only_arith: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q != K_ARITH) |-> !v_out);

  // R4: plain rotate leaves X as it came in
  a_r4_rot_keeps_x: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == K_ROT) |-> (x_out == x_cap));

  // R6: N follows the sign bit at the operation size
  a_r6_n_matches_msb: assert property (@(posedge clk) disable iff (rst)
    done |-> (n_out == msb_at_size));
endmodule

bind shrot_unit shrot_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .x_in(x_in), .busy(busy),
  .done(done), .result(result), .x_out(x_out), .n_out(n_out),
  .v_out(v_out), .kind_q(kind_q), .size_q(size_q)
);

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] opnd = '0;
  logic [1:0]  size_sel = '0, kind_sel = '0;
  logic        go_left = 1'b0, cnt_from_reg = 1'b0, mem_form = 1'b0, x_in = 1'b0;
  logic [2:0]  cnt_imm = '0;
  logic [31:0] cnt_reg = '0;
  logic        busy, done, x_out, n_out, z_out, v_out, c_out;
  logic [31:0] result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  shrot_unit u0 (
    .clk(clk), .rst(rst), .start(start), .opnd(opnd), .size_sel(size_sel),
    .kind_sel(kind_sel), .go_left(go_left), .cnt_from_reg(cnt_from_reg),
    .cnt_imm(cnt_imm), .cnt_reg(cnt_reg), .mem_form(mem_form), .x_in(x_in),
    .busy(busy), .done(done), .result(result), .x_out(x_out),
    .n_out(n_out), .z_out(z_out), .v_out(v_out), .c_out(c_out)
  );

  typedef struct packed {
    logic [31:0] op;
    logic [1:0]  sz;
    logic [1:0]  kd;
    logic        lf;
    logic        rg;
    logic [2:0]  im;
    logic [7:0]  rc;
    logic        mm;
    logic        xi;
    logic [31:0] er;
    logic [4:0]  ef;   // {X,N,Z,V,C}
    logic [6:0]  en;   // edges from start to done, counting the start edge
  } vec_t;

  localparam int NV = 13;
  // kind: 0 arith, 1 logical, 2 rotate through X, 3 rotate
  localparam vec_t VEC [NV] = '{
    // R1 R3: arithmetic left byte, sign crossed once
    '{32'h12345640, 2'd0, 2'd0, 1'b1, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0, 32'h12345680, 5'b01010, 7'd2},
    // R2 R4 R5: immediate 0 means 8, logical right word
    '{32'h0000ABCD, 2'd1, 2'd1, 1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 32'h000000AB, 5'b10001, 7'd9},
    // R1: arithmetic right replicates the sign
    '{32'h00000081, 2'd0, 2'd0, 1'b0, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 32'h000000E0, 5'b01000, 7'd3},
    // R1 R4: rotate left long, X held
    '{32'h80000001, 2'd2, 2'd3, 1'b1, 1'b0, 3'd4, 8'h00, 1'b0, 1'b1, 32'h00000018, 5'b10000, 7'd5},
    // R11 R6: rotate right through X byte, upper bits pass
    '{32'h0000FF00, 2'd0, 2'd2, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 1'b1, 32'h0000FF80, 5'b01000, 7'd2},
    // R2 R5: register 64 -> zero count, rotate through X: C equals X
    '{32'h00008000, 2'd1, 2'd2, 1'b1, 1'b1, 3'd0, 8'h40, 1'b0, 1'b1, 32'h00008000, 5'b11001, 7'd1},
    // R4 R5 R6: zero count logical: X kept, C cleared, Z at word size
    '{32'hFFFF0000, 2'd1, 2'd1, 1'b1, 1'b1, 3'd0, 8'h40, 1'b0, 1'b1, 32'hFFFF0000, 5'b10100, 7'd1},
    // R7: memory form ignores long size and count 5
    '{32'h11114000, 2'd2, 2'd0, 1'b1, 1'b0, 3'd5, 8'h00, 1'b1, 1'b0, 32'h11118000, 5'b01010, 7'd2},
    // R2: count 33 beyond the long width
    '{32'hFFFFFFFF, 2'd2, 2'd1, 1'b0, 1'b1, 3'd0, 8'h21, 1'b0, 1'b1, 32'h00000000, 5'b00100, 7'd34},
    // R3: sign changed early, V stays set
    '{32'h00000060, 2'd0, 2'd0, 1'b1, 1'b0, 3'd2, 8'h00, 1'b0, 1'b0, 32'h00000080, 5'b11011, 7'd3},
    // R1 R5: rotate right word
    '{32'h00000001, 2'd1, 2'd3, 1'b0, 1'b0, 3'd1, 8'h00, 1'b0, 1'b0, 32'h00008000, 5'b01001, 7'd2},
    // R11: rotate left through X byte by 3, 9-bit ring
    '{32'h000000A5, 2'd0, 2'd2, 1'b1, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 32'h0000002A, 5'b10001, 7'd4},
    // R3: sign never reached, V clear
    '{32'h00000001, 2'd0, 2'd0, 1'b1, 1'b0, 3'd3, 8'h00, 1'b0, 1'b0, 32'h00000008, 5'b00000, 7'd4}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    opnd = v.op; size_sel = v.sz; kind_sel = v.kd; go_left = v.lf;
    cnt_from_reg = v.rg; cnt_imm = v.im; cnt_reg = {24'h0, v.rc};
    mem_form = v.mm; x_in = v.xi;
  endtask

  task automatic run(input vec_t v, output int cyc);
    @(negedge clk);
    drive(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  function automatic logic [31:0] flg();
    return {27'h0, x_out, n_out, z_out, v_out, c_out};
  endfunction

  initial begin
    int cyc;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    chk("R10 busy", {31'h0, busy}, 32'h0);
    chk("R10 done", {31'h0, done}, 32'h0);
    chk("R10 result", result, 32'h0);
    chk("R10 flags", flg(), 32'h0);

    for (int i = 0; i < NV; i++) begin
      run(VEC[i], cyc);
      $display("vector %0d", i);
      chk("R1/R2/R6/R7/R11 result", result, VEC[i].er);
      chk("R3/R4/R5/R6 flags", flg(), {27'h0, VEC[i].ef});
      chk("R8 latency", cyc, {25'h0, VEC[i].en});
    end

    // R8: busy high during a multi-step operation
    @(negedge clk);
    drive(VEC[3]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 busy during run", {31'h0, busy}, 32'h1);
    // R9: second start while busy is ignored
    @(negedge clk);
    opnd = 32'h0000FFFF; kind_sel = 2'd1; x_in = 1'b0; cnt_imm = 3'd1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (!done && cyc < 300) begin
      @(negedge clk);
      cyc++;
    end
    chk("R9 result of first op", result, 32'h00000018);
    chk("R9 flags of first op", flg(), 32'h00000010);
    @(negedge clk);
    chk("R9 no extra completion", {31'h0, done}, 32'h0);
    chk("R9 idle afterwards", {31'h0, busy}, 32'h0);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule